// File: doc/BRIEF.md
# Up/Down Capture-Compare Timer Counter

This block is a 16-bit event timer for a control-oriented chip. A programmable prescaler divides the clock into count ticks, and a counter steps up or down by one on each tick. The direction comes from a software bit unless a hardware override input forces it. Counting needs two enables: a local one in the control byte and a chip-wide enable input. Two capture inputs copy the live count into their own holding registers. This happens whether or not the counter is running. A compare register is matched against the next count value.

Software uses a plain register port with a write strobe and a combinational read. Through it, software programs the compare value, the prescale divide value and the control byte, and reads back the captures, the live count and status. Optional modes clear the counter and restart the prescaler on a capture or on a compare match. A self-clearing clear bit zeroes the counter without raising an interrupt. The interrupt output pulses for captures, compare matches and counter wraps.

Top module: `updown_cc_timer`

## Requirements
- R1: After reset every control bit is 0, the count, compare, capture and prescale registers are 0, and `irq` is 0. With `dirForceEn` low, address 0 reads 0000h.
- R2: The counter and prescaler advance only while control bit 7 (run enable) and `globalEn` are both 1. Otherwise they hold their values, except for the clears in R6 and R8. Setting bit 7 again resumes from the held values.
- R3: Address 4 holds the prescale value P, in its low 8 bits. While running, a tick occurs in a cycle where the divide phase counter is at least P. That cycle resets the phase to 0. So there is one tick per P+1 cycles.
- R4: The direction is `dirForceUp` when `dirForceEn` is 1, and otherwise control bit 3 (1 = up, 0 = down). Read-only bit 2 shows the direction in use. On a tick the count changes by ±1 modulo 2^16.
- R5: A high `capTrig0` or `capTrig1` in a cycle copies the count held in that cycle into capture 0 (address 2) or capture 1 (address 3). This also happens while the counter is stopped.
- R6: With control bit 6 set, any capture clears the counter and restarts the prescaler phase.
- R7: A compare event happens on a tick whose next count equals the compare value (address 1). With control bit 5 set, the counter becomes 0 instead and the prescaler phase restarts.
- R8: Writing 1 to control bit 4 zeroes the counter at that edge. It causes no interrupt, does not touch the prescaler phase, and bit 4 always reads 0.
- R9: Read-only bit 1 is updated at each capture 0. It becomes 1 if a wrap (FFFFh→0000h up, 0000h→FFFFh down) happened after the previous capture 0, and 0 otherwise. A wrap in the capture cycle counts toward the next interval.
- R10: Read-only bit 0 reads 1 exactly while bit 7 and `globalEn` are both 1.
- R11: `irq` is high for one cycle after each cycle that held a capture, a compare event or a wrap.
- R12: When actions coincide, the counter takes the first that applies: CCL write, capture clear, compare clear, then a step. A compare event or wrap counts only when no CCL write or capture clear takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Chip-wide count enable, ANDed with bit 7 |
| dirForceEn | input | 1 | Hardware direction override active |
| dirForceUp | input | 1 | Forced direction, 1 = up |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: 0 control, 1 compare, 2 capture 0, 3 capture 1, 4 prescale, 5 count |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| capTrig0 | input | 1 | Capture 0 trigger, one cycle |
| capTrig1 | input | 1 | Capture 1 trigger, one cycle |
| count | output | 16 | Live counter value |
| irq | output | 1 | Interrupt pulse |

## Verification
The critical coincidence is a capture that clears the counter in the same cycle as a tick whose step would hit the compare value. It also covers a clear-bit write that lands on a tick. The bench provokes the first directly: it sets the compare value one step ahead and fires a capture on that exact tick. It then expects a zeroed counter, a capture of the old count, and an interrupt caused only by the capture. A long random phase then lets writes, triggers, enable changes and direction overrides collide freely. A behavioural model judges every cycle by applying the priority order of R12.

// File: rtl/updown_cc_timer_pkg.sv
package updown_cc_timer_pkg;

  // control byte bit positions (software decodes these)
  localparam int CTL_RUN  = 7;
  localparam int CTL_CCAP = 6;
  localparam int CTL_CCMP = 5;
  localparam int CTL_CLR  = 4;
  localparam int CTL_UP   = 3;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  typedef struct packed {
    logic cclClr;   // software clear, no interrupt
    logic capClr;   // capture-driven clear and prescaler restart
    logic cmpClr;   // compare-driven clear and prescaler restart
    logic cap0;     // load capture 0
    logic cap1;     // load capture 1
    logic wrCmp;    // write compare register
    logic wrPsc;    // write prescale register
  } tmrStrobes_t;

endpackage

// File: rtl/updown_cc_timer_ctrl.sv
module updown_cc_timer_ctrl
  import updown_cc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalEn,
  input  logic              dirForceEn,
  input  logic              dirForceUp,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrByte,
  input  logic              capTrig0,
  input  logic              capTrig1,
  input  logic              tick,
  input  logic              atWrapEdge,
  input  logic              stepHitsCmp,
  output tmrStrobes_t       strb,
  output logic              running,
  output logic              dirUp,
  output logic [7:0]        ctrlByte,
  output logic              irq
);

  logic runEn, clrOnCap, clrOnCmp, upSel;
  logic ovf0, wrapSeen;
  logic ctlWr, cclWr, capAny, capClr, cmpEvt, cmpClr, wrapNow;
  logic unusedLow;

  assign unusedLow = ^wrByte[2:0];

  assign running = runEn & globalEn;
  assign dirUp   = dirForceEn ? dirForceUp : upSel;

  assign ctlWr   = regWrEn && (regAddr == A_CTRL);
  assign cclWr   = ctlWr && wrByte[CTL_CLR];
  assign capAny  = capTrig0 | capTrig1;
  assign capClr  = clrOnCap & capAny;
  // priority: software clear, capture clear, compare clear, step
  assign cmpEvt  = tick & ~cclWr & ~capClr & stepHitsCmp;
  assign cmpClr  = cmpEvt & clrOnCmp;
  assign wrapNow = tick & ~cclWr & ~capClr & ~cmpClr & atWrapEdge;

  always_comb begin
    strb        = '0;
    strb.cclClr = cclWr;
    strb.capClr = capClr;
    strb.cmpClr = cmpClr;
    strb.cap0   = capTrig0;
    strb.cap1   = capTrig1;
    strb.wrCmp  = regWrEn && (regAddr == A_CMP);
    strb.wrPsc  = regWrEn && (regAddr == A_PSC);
  end

  assign ctrlByte = {runEn, clrOnCap, clrOnCmp, 1'b0, upSel, dirUp, ovf0, running};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      clrOnCap <= 1'b0;
      clrOnCmp <= 1'b0;
      upSel    <= 1'b0;
      ovf0     <= 1'b0;
      wrapSeen <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ctlWr) begin
        runEn    <= wrByte[CTL_RUN];
        clrOnCap <= wrByte[CTL_CCAP];
        clrOnCmp <= wrByte[CTL_CCMP];
        upSel    <= wrByte[CTL_UP];
      end
      irq <= capAny | cmpEvt | wrapNow;
      if (capTrig0) begin
        ovf0     <= wrapSeen;
        wrapSeen <= wrapNow;
      end else if (wrapNow) begin
        wrapSeen <= 1'b1;
      end
    end
  end

  // R8: a software clear alone never raises the interrupt
  p_ccl_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cclWr && !capTrig0 && !capTrig1) |=> !irq);

  // R11: every interrupt pulse follows a capture or a tick
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(capTrig0 || capTrig1 || tick));

endmodule

// File: rtl/updown_cc_timer_dp.sv
module updown_cc_timer_dp
  import updown_cc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  logic             dirUp,
  input  tmrStrobes_t      strb,
  input  logic [CNT_W-1:0] wrData,
  output logic             tick,
  output logic             atWrapEdge,
  output logic             stepHitsCmp,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cap0Val,
  output logic [CNT_W-1:0] cap1Val,
  output logic [PSC_W-1:0] pscVal
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] divCnt;
  logic [CNT_W-1:0] stepVal;
  logic             anyClr, phaseRst;

  assign tick        = running && (divCnt >= pscVal);
  assign stepVal     = dirUp ? (count + CNT_ONE) : (count - CNT_ONE);
  assign atWrapEdge  = dirUp ? (&count) : ~(|count);
  assign stepHitsCmp = (stepVal == cmpVal);
  assign anyClr      = strb.cclClr | strb.capClr | strb.cmpClr;
  assign phaseRst    = strb.capClr | strb.cmpClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      divCnt <= '0;
    end else begin
      if (anyClr)    count <= '0;
      else if (tick) count <= stepVal;

      if (phaseRst || tick) divCnt <= '0;
      else if (running)     divCnt <= divCnt + PSC_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal  <= '0;
      pscVal  <= '0;
      cap0Val <= '0;
      cap1Val <= '0;
    end else begin
      if (strb.wrCmp) cmpVal  <= wrData;
      if (strb.wrPsc) pscVal  <= wrData[PSC_W-1:0];
      if (strb.cap0)  cap0Val <= count;
      if (strb.cap1)  cap1Val <= count;
    end
  end

  // R2: stopped and not cleared means the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.cclClr && !strb.capClr) |=> $stable(count));

  // R4: an unobstructed up tick adds exactly one, wrapping at the top
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && dirUp && !anyClr) |=> (count == $past(count) + CNT_ONE));

  // R5: capture 0 holds the count of the trigger cycle
  p_cap0_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap0 |=> (cap0Val == $past(count)));

  // R6: a capture clear leaves both counter and phase at zero
  p_cap_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capClr |=> (count == '0 && divCnt == '0));

  // R8: software clear zeroes the count
  p_ccl_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.cclClr |=> (count == '0));

endmodule

// File: rtl/updown_cc_timer.sv
module updown_cc_timer
  import updown_cc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalEn,
  input  logic              dirForceEn,
  input  logic              dirForceUp,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              capTrig0,
  input  logic              capTrig1,
  output logic [CNT_W-1:0]  count,
  output logic              irq
);

  tmrStrobes_t      strb;
  logic             running, dirUp, tick, atWrapEdge, stepHitsCmp;
  logic [7:0]       ctrlByte;
  logic [CNT_W-1:0] cmpVal, cap0Val, cap1Val;
  logic [PSC_W-1:0] pscVal;

  updown_cc_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .globalEn(globalEn),
    .dirForceEn(dirForceEn), .dirForceUp(dirForceUp),
    .regWrEn(regWrEn), .regAddr(regAddr), .wrByte(regWrData[7:0]),
    .capTrig0(capTrig0), .capTrig1(capTrig1),
    .tick(tick), .atWrapEdge(atWrapEdge), .stepHitsCmp(stepHitsCmp),
    .strb(strb), .running(running), .dirUp(dirUp),
    .ctrlByte(ctrlByte), .irq(irq)
  );

  updown_cc_timer_dp #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .running(running), .dirUp(dirUp),
    .strb(strb), .wrData(regWrData),
    .tick(tick), .atWrapEdge(atWrapEdge), .stepHitsCmp(stepHitsCmp),
    .count(count), .cmpVal(cmpVal), .cap0Val(cap0Val),
    .cap1Val(cap1Val), .pscVal(pscVal)
  );

  always_comb begin
    unique case (regAddr)
      A_CTRL:  regRdData = CNT_W'(ctrlByte);
      A_CMP:   regRdData = cmpVal;
      A_CAP0:  regRdData = cap0Val;
      A_CAP1:  regRdData = cap1Val;
      A_PSC:   regRdData = CNT_W'(pscVal);
      A_CNT:   regRdData = count;
      default: regRdData = '0;
    endcase
  end

endmodule

// File: tb/updown_cc_timer_tb.sv
module updown_cc_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b1;
  logic        dirForceEn = 1'b0;
  logic        dirForceUp = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'h0;
  logic        capTrig0 = 1'b0;
  logic        capTrig1 = 1'b0;
  logic [15:0] regRdData, count;
  logic        irq;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural model state
  logic [15:0] mCnt, mCmp, mCap0, mCap1, mAdv;
  logic [7:0]  mPsc, mDiv, mNewDiv;
  bit mCen, mCcp, mCcmp, mUdc, mOf0, mWrapSeen, mIrq;
  bit mRun, mUp, mTk, mCtlW, mCclW, mCapClr, mCmpEv, mCmpClr, mWrap;

  updown_cc_timer u_dut (
    .clk(clk), .rstN(rstN), .globalEn(globalEn),
    .dirForceEn(dirForceEn), .dirForceUp(dirForceUp),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .capTrig0(capTrig0), .capTrig1(capTrig1),
    .count(count), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expRd(input logic [2:0] a);
    bit up;
    up = dirForceEn ? dirForceUp : mUdc;
    case (a)
      3'd0: return {8'h00, mCen, mCcp, mCcmp, 1'b0, mUdc, up, mOf0, (mCen && globalEn)};
      3'd1: return mCmp;
      3'd2: return mCap0;
      3'd3: return mCap1;
      3'd4: return {8'h00, mPsc};
      3'd5: return mCnt;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mCap0 = 0; mCap1 = 0; mPsc = 0; mDiv = 0;
      mCen = 0; mCcp = 0; mCcmp = 0; mUdc = 0; mOf0 = 0; mWrapSeen = 0; mIrq = 0;
    end else begin
      mRun    = mCen && globalEn;
      mUp     = dirForceEn ? dirForceUp : mUdc;
      mTk     = mRun && (mDiv >= mPsc);
      mAdv    = mUp ? mCnt + 16'd1 : mCnt - 16'd1;
      mCtlW   = regWrEn && regAddr == 3'd0;
      mCclW   = mCtlW && regWrData[4];
      mCapClr = mCcp && (capTrig0 || capTrig1);
      mCmpEv  = mTk && !mCclW && !mCapClr && (mAdv == mCmp);
      mCmpClr = mCmpEv && mCcmp;
      mWrap   = mTk && !mCclW && !mCapClr && !mCmpClr &&
                (mUp ? (mCnt == 16'hFFFF) : (mCnt == 16'h0000));
      mIrq    = capTrig0 || capTrig1 || mCmpEv || mWrap;
      if (capTrig0) begin
        mCap0 = mCnt; mOf0 = mWrapSeen; mWrapSeen = mWrap;
      end else if (mWrap) mWrapSeen = 1;
      if (capTrig1) mCap1 = mCnt;
      mNewDiv = (mCapClr || mCmpClr || mTk) ? 8'd0 : (mRun ? mDiv + 8'd1 : mDiv);
      if (mCclW || mCapClr || mCmpClr) mCnt = 0;
      else if (mTk) mCnt = mAdv;
      mDiv = mNewDiv;
      if (mCtlW) begin
        mCen = regWrData[7]; mCcp = regWrData[6]; mCcmp = regWrData[5]; mUdc = regWrData[3];
      end
      if (regWrEn && regAddr == 3'd1) mCmp = regWrData;
      if (regWrEn && regAddr == 3'd4) mPsc = regWrData[7:0];
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, count, mCnt);
      check(curReq, {15'd0, irq}, {15'd0, mIrq});
      check(curReq, regRdData, expRd(regAddr));
    end
  end

  task automatic nextCyc();
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
    capTrig0 = 1'b0;
    capTrig1 = 1'b0;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    nextCyc();
  endtask

  task automatic idle(input int n);
    repeat (n) nextCyc();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    regAddr = 3'd0;
    #1;
    check("R1", regRdData, 16'h0000);
    check("R1", count, 16'h0000);
    check("R1", {15'd0, irq}, 16'h0000);
    idle(2);

    // R3: divide by three, counting up
    curReq = "R3";
    wrReg(3'd4, 16'h0002);
    wrReg(3'd0, 16'h0088);
    idle(30);

    // R2: local stop, then global stop
    curReq = "R2";
    wrReg(3'd0, 16'h0008);
    idle(10);
    wrReg(3'd0, 16'h0088);
    globalEn = 1'b0;
    idle(10);
    globalEn = 1'b1;
    curReq = "R10";
    regAddr = 3'd0;
    idle(4);
    #1 check("R10", {15'd0, regRdData[0]}, 16'd1);

    // R9: underflow then capture 0
    curReq = "R9";
    wrReg(3'd4, 16'h0000);
    wrReg(3'd0, 16'h0090);   // run, clear, down
    idle(3);
    capTrig0 = 1'b1;
    nextCyc();
    regAddr = 3'd0;
    #1 check("R9", {15'd0, regRdData[1]}, 16'd1);
    capTrig0 = 1'b1;
    nextCyc();
    #1 check("R9", {15'd0, regRdData[1]}, 16'd0);
    curReq = "R11";
    idle(4);

    // R5: captures while stopped
    curReq = "R5";
    wrReg(3'd0, 16'h0000);
    capTrig0 = 1'b1;
    capTrig1 = 1'b1;
    nextCyc();
    regAddr = 3'd2;
    #1 check("R5", regRdData, count);
    regAddr = 3'd3;
    #1 check("R5", regRdData, count);
    idle(2);

    // R6: capture clear
    curReq = "R6";
    wrReg(3'd4, 16'h0003);
    wrReg(3'd0, 16'h00C8);
    idle(9);
    capTrig1 = 1'b1;
    nextCyc();
    #1 check("R6", count, 16'h0000);
    idle(3);

    // R7: compare clear with period of five ticks
    curReq = "R7";
    wrReg(3'd4, 16'h0000);
    wrReg(3'd1, 16'h0005);
    wrReg(3'd0, 16'h00B8);
    for (int i = 0; i < 20; i++) begin
      nextCyc();
      #1 check("R7", {15'd0, (count < 16'd5)}, 16'd1);
    end

    // R8: software clear
    curReq = "R8";
    wrReg(3'd0, 16'h0098);
    regAddr = 3'd0;
    #1;
    check("R8", count, 16'h0000);
    check("R8", {15'd0, regRdData[4]}, 16'd0);
    check("R8", {15'd0, irq}, 16'd0);
    idle(3);

    // R4: hardware override, then software down
    curReq = "R4";
    dirForceEn = 1'b1;
    dirForceUp = 1'b0;
    idle(8);
    dirForceUp = 1'b1;
    idle(8);
    dirForceEn = 1'b0;
    wrReg(3'd0, 16'h0080);
    idle(8);

    // R12: capture clear on the cycle of a compare step
    curReq = "R12";
    wrReg(3'd1, 16'd10);
    wrReg(3'd0, 16'h00F8);   // run, both clears, soft clear, up
    idle(9);
    capTrig0 = 1'b1;
    nextCyc();
    regAddr = 3'd2;
    #1;
    check("R12", count, 16'h0000);
    check("R12", regRdData, 16'd9);
    check("R12", {15'd0, irq}, 16'd1);

    // random collisions, judged by the model
    for (int i = 0; i < 3000; i++) begin
      capTrig0 = ($urandom % 16) == 0;
      capTrig1 = ($urandom % 16) == 0;
      if (($urandom % 24) == 0) begin
        regWrEn = 1'b1; regAddr = 3'd0; regWrData = {8'h00, 8'($urandom)};
      end else if (($urandom % 40) == 0) begin
        regWrEn = 1'b1; regAddr = 3'd1; regWrData = 16'($urandom % 48);
      end else if (($urandom % 40) == 0) begin
        regWrEn = 1'b1; regAddr = 3'd4; regWrData = 16'($urandom % 4);
      end else begin
        regAddr = 3'($urandom % 8);
      end
      if (($urandom % 30) == 0) globalEn = ~globalEn;
      if (($urandom % 50) == 0) dirForceEn = ~dirForceEn;
      if (($urandom % 20) == 0) dirForceUp = ~dirForceUp;
      nextCyc();
    end

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule